// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block runs the bus handshake that answers a maskable interrupt request on a processor with a multiplexed address/data bus. At an instruction boundary, the core samples the interrupt-enable flag and the request line. If both are high, the sequencer issues two acknowledge bus cycles with a fixed idle gap between them. It drives the acknowledge strobe, the address latch pulse, the memory/IO select and an internal lock. The lock keeps a bus-grant arbiter from handing the bus away between the two cycles.

The data bus is ignored during the first acknowledge cycle. In the second cycle, the low byte of the data bus is taken as the interrupt type. One clock after the second cycle ends, the captured type is offered to the dispatcher together with a one-clock valid strobe. Each acknowledge cycle has four clocks. In clock 1 the latch pulse is high. In clocks 2 and 3 the acknowledge strobe is low.

Top module: `intack_seq`

## Requirements
- R1: Out of reset, inta_n=1, ale=0, mio=1 (memory), lock=0, type_valid=0, busy=0 and type_code=0.
- R2: A sequence starts only when insn_end, if_flag and intr are all 1 at the same rising edge while the block is idle. Any other combination leaves every output unchanged.
- R3: Each acknowledge cycle lasts four clocks. ale=1 in the first clock, inta_n=0 in the second and third clocks, and neither strobe is active in the fourth clock.
- R4: Exactly GAP_CLKS clocks (default 2) separate the fourth clock of the first cycle from the first clock of the second cycle. In those clocks inta_n=1 and ale=0.
- R5: mio=0 (I/O) from the first clock of the first cycle through the fourth clock of the second cycle, gap included. Otherwise mio=1.
- R6: lock=1 from the second clock of the first cycle through the second clock of the second cycle. Otherwise lock=0.
- R7: type_code takes the value of data_in at the rising edge that ends the third clock of the second cycle. Data during the first cycle is never captured, and type_code holds its value at all other times.
- R8: type_valid is 1 for exactly the one clock that follows the fourth clock of the second cycle.
- R9: busy=1 from the first clock of the first cycle through the type_valid clock. Requests sampled while busy are ignored, so a request held high starts the next sequence only after one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_end | input | 1 | Current instruction completes this clock |
| if_flag | input | 1 | Interrupt-enable flag of the core |
| intr | input | 1 | Maskable interrupt request |
| data_in | input | DATA_W | Low byte of the data bus |
| inta_n | output | 1 | Acknowledge strobe, active low |
| ale | output | 1 | Address latch enable pulse |
| mio | output | 1 | 1 = memory, 0 = I/O access |
| lock | output | 1 | Internal lock refusing bus grants |
| busy | output | 1 | Sequence in progress |
| type_code | output | DATA_W | Captured interrupt type |
| type_valid | output | 1 | One-clock strobe for type_code |

## Verification
Take the rising edge that samples the start condition as edge 0. The first cycle's ale shows in the clock after edge 0, and inta_n is low in clocks 2 and 3. The gap fills clocks 5 and 6, and the second cycle fills clocks 7 to 10. The type is latched at edge 9, and type_valid is high in clock 11. The bench keeps a step count that advances at each rising edge and works out all expected outputs from it. It compares them against the design on every falling edge, half a period after the registers have settled, and drives the inputs on those same falling edges. Random data is placed on the bus in every clock, so a capture one edge early or late, or in the first cycle, produces a wrong type_code.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_T3,
    PH_T4,
    PH_GAP,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
#(
  parameter int GAP_CLKS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   second
);
  localparam int GW = (GAP_CLKS < 2) ? 1 : $clog2(GAP_CLKS + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CLKS - 1);

  phase_t        phase_d;
  logic          second_d;
  logic [GW-1:0] gap_q, gap_d;

  // next-state process
  always_comb begin
    phase_d  = phase;
    second_d = second;
    gap_d    = gap_q;
    unique case (phase)
      PH_IDLE: if (start) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = PH_T4;
      PH_T4: begin
        if (second) begin
          phase_d = PH_DONE;
        end else begin
          phase_d = PH_GAP;
          gap_d   = GAP_LOAD;
        end
      end
      PH_GAP: begin
        if (gap_q == '0) begin
          phase_d  = PH_T1;
          second_d = 1'b1;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      PH_DONE: begin
        phase_d  = PH_IDLE;
        second_d = 1'b0;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      second <= 1'b0;
      gap_q  <= '0;
    end else begin
      phase  <= phase_d;
      second <= second_d;
      gap_q  <= gap_d;
    end
  end
endmodule

// File: rtl/intack_decode.sv
module intack_decode
  import intack_pkg::*;
(
  input  phase_t phase,
  input  logic   second,
  output logic   inta_n,
  output logic   ale,
  output logic   mio,
  output logic   lock,
  output logic   busy
);
  logic first_lock, second_lock;

  always_comb begin
    ale    = (phase == PH_T1);
    inta_n = !((phase == PH_T2) || (phase == PH_T3));
    mio    = (phase == PH_IDLE) || (phase == PH_DONE);
    busy   = (phase != PH_IDLE);
    first_lock  = !second && ((phase == PH_T2) || (phase == PH_T3) ||
                              (phase == PH_T4) || (phase == PH_GAP));
    second_lock = second && ((phase == PH_T1) || (phase == PH_T2));
    lock   = first_lock || second_lock;
  end
endmodule

// File: rtl/intack_capture.sv
module intack_capture
  import intack_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              second,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] type_code,
  output logic              type_valid
);
  logic cap_en;
  logic valid_d;

  always_comb begin
    cap_en  = second && (phase == PH_T3);
    valid_d = second && (phase == PH_T4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_code <= '0;
    end else if (cap_en) begin
      type_code <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) type_valid <= 1'b0;
    else        type_valid <= valid_d;
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GAP_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  logic              if_flag,
  input  logic              intr,
  input  logic [DATA_W-1:0] data_in,
  output logic              inta_n,
  output logic              ale,
  output logic              mio,
  output logic              lock,
  output logic              busy,
  output logic [DATA_W-1:0] type_code,
  output logic              type_valid
);
  phase_t phase;
  logic   second;
  logic   start;

  assign start = insn_end && if_flag && intr;

  intack_ctrl #(.GAP_CLKS(GAP_CLKS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .phase  (phase),
    .second (second)
  );

  intack_decode u_dec (
    .phase  (phase),
    .second (second),
    .inta_n (inta_n),
    .ale    (ale),
    .mio    (mio),
    .lock   (lock),
    .busy   (busy)
  );

  intack_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .second     (second),
    .data_in    (data_in),
    .type_code  (type_code),
    .type_valid (type_valid)
  );
endmodule

// File: rtl/intack_chk.sv
module intack_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inta_n,
  input logic              ale,
  input logic              mio,
  input logic              lock,
  input logic              busy,
  input logic [DATA_W-1:0] type_code,
  input logic              type_valid
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (inta_n && !ale && mio && !lock && !type_valid));

  p_ale_then_inta_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!inta_n && !ale));

  p_inta_two_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inta_n && $past(!inta_n)) |=> inta_n);

  p_io_during_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !inta_n || lock) |-> !mio);

  p_lock_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (!inta_n && $past(ale)));

  p_capture_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(type_code) |-> ($past(!inta_n) && $past(!lock)));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    type_valid |=> !type_valid);

  p_valid_after_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
    type_valid |-> (busy && mio && $past(!mio && inta_n && !ale)));
endmodule

bind intack_seq intack_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inta_n     (inta_n),
  .ale        (ale),
  .mio        (mio),
  .lock       (lock),
  .busy       (busy),
  .type_code  (type_code),
  .type_valid (type_valid)
);

// File: tb/sim_intack_seq.sv
`timescale 1ns/1ps
module sim_intack_seq;
  localparam int DW  = 8;
  localparam int GAP = 2;
  localparam int LAST = 9 + GAP;   // step number of the valid clock

  logic          clk = 1'b0;
  logic          rst_n;
  logic          insn_end, if_flag, intr;
  logic [DW-1:0] data_in;
  logic          inta_n, ale, mio, lock, busy, type_valid;
  logic [DW-1:0] type_code;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state: step 0 idle, 1..LAST inside a sequence
  int            step = 0;
  logic [DW-1:0] exp_code = '0;

  always #4 clk = ~clk;

  intack_seq #(.DATA_W(DW), .GAP_CLKS(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .if_flag(if_flag),
    .intr(intr), .data_in(data_in), .inta_n(inta_n), .ale(ale), .mio(mio),
    .lock(lock), .busy(busy), .type_code(type_code), .type_valid(type_valid)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     = 0;
      exp_code = '0;
    end else begin
      if (step == 7 + GAP) exp_code = data_in;   // end of third clock, second cycle
      if (step == 0) step = (insn_end && if_flag && intr) ? 1 : 0;
      else           step = (step == LAST) ? 0 : step + 1;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step=%0d actual=%h expected=%h", tag, step, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // compare every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int  s   = step;
      automatic bit  c1  = (s >= 1) && (s <= 4);
      automatic bit  gp  = (s >= 5) && (s <= 4 + GAP);
      automatic bit  c2  = (s >= 5 + GAP) && (s <= 8 + GAP);
      automatic int  ph  = c1 ? s : (c2 ? s - 4 - GAP : 0);
      automatic bit  e_ale  = (c1 || c2) && (ph == 1);
      automatic bit  e_inta = !((c1 || c2) && (ph == 2 || ph == 3));
      automatic bit  e_mio  = !(c1 || gp || c2);
      automatic bit  e_lock = (c1 && ph >= 2) || gp || (c2 && ph <= 2);
      chk("R3 ale", DW'(ale), DW'(e_ale));
      chk("R3/R4 inta_n", DW'(inta_n), DW'(e_inta));
      chk("R5 mio", DW'(mio), DW'(e_mio));
      chk("R6 lock", DW'(lock), DW'(e_lock));
      chk("R9 busy", DW'(busy), DW'(s != 0));
      chk("R8 type_valid", DW'(type_valid), DW'(s == LAST));
      chk("R7 type_code", type_code, exp_code);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  task automatic drive(input int n, input bit ie, input bit fl, input bit rq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      insn_end = ie; if_flag = fl; intr = rq;
      data_in  = DW'($urandom);
    end
  endtask

  initial begin
    rst_n = 1'b0; insn_end = 0; if_flag = 0; intr = 0; data_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 inta_n", DW'(inta_n), 8'd1);
    chk("R1 ale", DW'(ale), 8'd0);
    chk("R1 mio", DW'(mio), 8'd1);
    chk("R1 lock", DW'(lock), 8'd0);
    chk("R1 busy", DW'(busy), 8'd0);
    chk("R1 type_valid", DW'(type_valid), 8'd0);
    chk("R1 type_code", type_code, 8'd0);
    rst_n = 1'b1;
    drive(3, 0, 0, 0);
    // R2: partial conditions start nothing
    drive(6, 1, 0, 1);
    drive(6, 1, 1, 0);
    drive(6, 0, 1, 1);
    // single accepted request, then quiet through the whole sequence
    drive(1, 1, 1, 1);
    drive(16, 0, 0, 0);
    // R9: request held high throughout, back-to-back sequences
    drive(40, 1, 1, 1);
    drive(16, 0, 1, 1);
    // random traffic
    for (int k = 0; k < 300; k++) drive(1, $urandom_range(0, 1) != 0,
                                        $urandom_range(0, 3) != 0,
                                        $urandom_range(0, 1) != 0);
    drive(16, 0, 0, 0);
    // mid-sequence reset returns to R1 state
    drive(1, 1, 1, 1);
    drive(5, 0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", DW'(busy), 8'd0);
    chk("R1 code after reset", type_code, 8'd0);
    rst_n = 1'b1;
    drive(4, 0, 0, 0);
    finish_run();
  end
endmodule